// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs the two-wire station management link of an Ethernet PHY. Software talks to it through one 32-bit command word. A single write to that word carries the PHY address, the register address, a read or write request and, for writes, sixteen bits of data. The block then produces a complete management frame on MDC/MDIO: a long run of ones, the start, opcode and address fields, and then either the write data or a released turnaround followed by capture of the PHY's reply. When the frame has finished, a done flag in the same word is set, and a read result replaces the data field.

MDC is made by dividing the system clock. The `mdc_half` input sets how many system clocks each MDC high phase and each low phase lasts. It must be chosen so that MDC stays at or below 2.5 MHz. The pad is outside the block. `mdio_o` and `mdio_oe` feed an external tri-state buffer, and `mdio_i` returns the pin level. One request runs at a time.

The command word also has a register-address extension bit. A request that sets this bit names a register above 31. Such a request is refused without any bus activity.

Top module: `mdio_master`

## Requirements
- R1: Every MDC high phase and every MDC low phase lasts exactly `mdc_half` system clocks (a value of 0 acts as 1). MDC rests low between frames and after reset.
- R2: Every frame begins with 33 MDC cycles in which MDIO is driven to one.
- R3: In a read frame, MDC cycles 33 to 46 drive start `01`, opcode `10`, the 5-bit PHY address and the 5-bit register address, each field MSB first.
- R4: In a read frame, MDIO is released for MDC cycles 47 to 65, making 66 cycles in total. The levels sampled in cycles 49 to 64 form the result, MSB first, and it is placed in data bits 15:0.
- R5: A write frame drives 32 bits in cycles 33 to 64: `01`, `01`, PHY address, register address, `10`, then the 16 data bits MSB first. MDIO is then released for 2 more cycles, making 67 in total.
- R6: The MDIO output changes only at the start of an MDC low phase and holds through the following high phase. MDIO input is sampled on the last system clock of the low phase.
- R7: Command word layout: bit 29 is the register-address extension, bit 28 is done, bit 27 is the read request, bit 26 is the write request, bits 25:21 are the PHY address, bits 20:16 are the register address and bits 15:0 are the data. On readback, bits 27 and 26 show which frame is in progress, and bits 31:30 read as zero.
- R8: A request with bit 29 set starts no frame. A read of this kind completes on the next clock with data 0xFFFF. A write of this kind sets done and leaves the data field unchanged.
- R9: Accepting a request clears done. Done is set again when the frame ends.
- R10: A command write that arrives while a frame is in progress has no effect on that frame or on the stored fields.
- R11: When bits 27 and 26 are both set in one write, a read frame is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_half | input | DIV_W | System clocks per MDC half period |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Command word readback and status |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pin level |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Read frames are run with reply words of alternating bits, all zeros, all ones and mixed values. These show whether the sixteen sampled cycles land in the right bit order and whether the two turnaround cycles and the idle cycle are kept out of the result. Write frames are run with all-zero, all-one and mixed data, and with the extreme PHY and register addresses. Each transmitted bit is compared, so a slipped field, a wrong opcode or a short preamble shows as a miscompare in a known cycle. Further cases cover: a refused read and a refused write, where no MDC edge may appear; a second request during a frame, which must not alter the captured frame; and a request with both bits set, which must yield a 66-cycle read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_CYC   = 33;
    localparam int RD_HDR    = 14;
    localparam int RD_TAIL   = 19;
    localparam int WR_BODY   = 32;
    localparam int WR_TAIL   = 2;
    localparam int SH_W      = PRE_CYC + WR_BODY;
    localparam int RD_DRIVE  = PRE_CYC + RD_HDR;
    localparam int RD_TOTAL  = RD_DRIVE + RD_TAIL;
    localparam int WR_TOTAL  = SH_W + WR_TAIL;
    localparam int BIT_CNT_W = $clog2(WR_TOTAL + 1);

    localparam int POS_EXT  = 29;
    localparam int POS_DONE = 28;
    localparam int POS_RD   = 27;
    localparam int POS_WR   = 26;

    typedef enum logic {FR_IDLE, FR_ACTIVE} frame_st_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } div_s;

    div_s div_d, div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim       = (half == '0) ? DIV_W'(1) : half;
        div_d     = div_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!run) begin
            div_d = '0;
        end else if (div_q.cnt >= lim - DIV_W'(1)) begin
            div_d.cnt = '0;
            div_d.ph  = ~div_q.ph;
            rise_tick = ~div_q.ph;
            fall_tick = div_q.ph;
        end else begin
            div_d.cnt = div_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.ph;

    AST_MDC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(rise_tick || fall_tick)); // R1
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        finish,
    output logic [15:0] rdata
);
    typedef struct packed {
        frame_st_e             st;
        logic                  rd;
        logic [BIT_CNT_W-1:0]  bitn;
        logic [SH_W-1:0]       sh;
        logic [RD_TAIL-1:0]    rx;
    } fr_s;

    fr_s fr_d, fr_q;
    logic [BIT_CNT_W-1:0] last_cyc;
    logic [BIT_CNT_W-1:0] drive_len;

    always_comb begin
        last_cyc  = fr_q.rd ? BIT_CNT_W'(RD_TOTAL - 1) : BIT_CNT_W'(WR_TOTAL - 1);
        drive_len = fr_q.rd ? BIT_CNT_W'(RD_DRIVE) : BIT_CNT_W'(SH_W);
        fr_d      = fr_q;
        finish    = 1'b0;
        case (fr_q.st)
            FR_IDLE: begin
                if (start) begin
                    fr_d.st   = FR_ACTIVE;
                    fr_d.rd   = is_read;
                    fr_d.bitn = '0;
                    fr_d.rx   = '0;
                    if (is_read)
                        fr_d.sh = {{PRE_CYC{1'b1}}, 2'b01, 2'b10, phy, regad,
                                   {(SH_W - RD_DRIVE){1'b0}}};
                    else
                        fr_d.sh = {{PRE_CYC{1'b1}}, 2'b01, 2'b01, phy, regad,
                                   2'b10, wdata};
                end
            end
            default: begin
                if (rise_tick && fr_q.rd && fr_q.bitn >= BIT_CNT_W'(RD_DRIVE))
                    fr_d.rx = {fr_q.rx[RD_TAIL-2:0], mdio_i};
                if (fall_tick) begin
                    fr_d.sh = {fr_q.sh[SH_W-2:0], 1'b0};
                    if (fr_q.bitn == last_cyc) begin
                        fr_d.st = FR_IDLE;
                        finish  = 1'b1;
                    end else begin
                        fr_d.bitn = fr_q.bitn + BIT_CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign run     = (fr_q.st == FR_ACTIVE);
    assign mdio_oe = run && (fr_q.bitn < drive_len);
    assign mdio_o  = mdio_oe & fr_q.sh[SH_W-1];
    assign rdata   = fr_q.rx[16:1];

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        run && fr_q.bitn < BIT_CNT_W'(PRE_CYC) |-> mdio_oe && mdio_o); // R2
    AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        run && !mdio_oe |=> !mdio_oe); // R4
    AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$stable(fr_q.sh) |-> $past(fall_tick)); // R6
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] mdc_half,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    typedef struct packed {
        logic        ext;
        logic        done;
        logic        rd;
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic        start;
    } cmd_s;

    cmd_s cmd_d, cmd_q;
    logic busy, accept, req_rd, req_wr;
    logic run, rise_tick, fall_tick, finish;
    logic [15:0] rx_data;

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.start = 1'b0;
        busy        = cmd_q.rd | cmd_q.wr;
        req_rd      = cmd_wdata[POS_RD];
        req_wr      = cmd_wdata[POS_WR];
        accept      = cmd_we && (req_rd || req_wr) && !busy;
        if (finish) begin
            cmd_d.done = 1'b1;
            cmd_d.rd   = 1'b0;
            cmd_d.wr   = 1'b0;
            if (cmd_q.rd) cmd_d.data = rx_data;
        end
        if (accept) begin
            cmd_d.ext   = cmd_wdata[POS_EXT];
            cmd_d.phy   = cmd_wdata[25:21];
            cmd_d.regad = cmd_wdata[20:16];
            cmd_d.done  = 1'b0;
            if (cmd_wdata[POS_EXT]) begin
                cmd_d.done = 1'b1;
                if (req_rd) cmd_d.data = 16'hFFFF;
            end else begin
                cmd_d.start = 1'b1;
                if (req_rd) begin
                    cmd_d.rd = 1'b1;
                end else begin
                    cmd_d.wr   = 1'b1;
                    cmd_d.data = cmd_wdata[15:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_rdata = {2'b00, cmd_q.ext, cmd_q.done, cmd_q.rd, cmd_q.wr,
                        cmd_q.phy, cmd_q.regad, cmd_q.data};

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half      (mdc_half),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_q.start),
        .is_read   (cmd_q.rd),
        .phy       (cmd_q.phy),
        .regad     (cmd_q.regad),
        .wdata     (cmd_q.data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .finish    (finish),
        .rdata     (rx_data)
    );

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)); // R6
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_we |=> $stable(cmd_q.phy) && $stable(cmd_q.regad)); // R10
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && (cmd_wdata[POS_RD] || cmd_wdata[POS_WR]) && !busy
        && !cmd_wdata[POS_EXT] |=> !cmd_q.done); // R9
    AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_wdata[POS_EXT] |=> !cmd_q.start && !busy); // R8
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_i, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mdio_master #(.DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mdc_half(8'(H)), .cmd_we(cmd_we),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model and monitor
    logic [0:79] resp = '1;
    logic [0:79] cap_o, cap_oe, exp_o, exp_oe;
    int rises = 0, cyc = 0, cur_len = 0, bad_hi = 0, bad_lo = 0, exp_n = 0;
    logic prev_mdc = 1'b0, after_fall = 1'b0;

    assign mdio_i = (cyc < 80) ? resp[cyc] : 1'b1;

    always @(negedge clk) begin
        if (cmd_we && !(cmd_rdata[27] | cmd_rdata[26])) begin
            rises = 0; cyc = 0; after_fall = 1'b0; bad_hi = 0; bad_lo = 0;
        end
        if (mdc && !prev_mdc) begin
            if (after_fall && cur_len != H) bad_lo++;
            if (rises < 80) begin cap_o[rises] = mdio_o; cap_oe[rises] = mdio_oe; end
            rises++;
            cur_len = 1;
        end else if (!mdc && prev_mdc) begin
            if (cur_len != H) bad_hi++;
            after_fall = 1'b1;
            cyc = rises;
            cur_len = 1;
        end else begin
            cur_len++;
        end
        prev_mdc = mdc;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(posedge clk); #1;
        cmd_we = 1'b1; cmd_wdata = w;
        @(posedge clk); #1;
        cmd_we = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (cmd_rdata[28]) break;
        end
    endtask

    task automatic build_exp(input logic rd, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd,
                             input logic [15:0] rsp);
        logic [31:0] body;
        exp_o = '0; exp_oe = '0; resp = '1;
        for (int i = 0; i < 33; i++) begin exp_o[i] = 1'b1; exp_oe[i] = 1'b1; end
        if (rd) begin
            body = {2'b01, 2'b10, phy, rg, 18'h0};
            for (int j = 0; j < 14; j++) begin exp_o[33+j] = body[31-j]; exp_oe[33+j] = 1'b1; end
            resp[48] = 1'b0;
            for (int j = 0; j < 16; j++) resp[49+j] = rsp[15-j];
            exp_n = 66;
        end else begin
            body = {2'b01, 2'b01, phy, rg, 2'b10, wd};
            for (int j = 0; j < 32; j++) begin exp_o[33+j] = body[31-j]; exp_oe[33+j] = 1'b1; end
            exp_n = 67;
        end
    endtask

    task automatic check_frame(input string req);
        int bad = 0;
        for (int i = 0; i < 80; i++) begin
            if (i < exp_n && cap_oe[i] !== exp_oe[i]) bad++;
            if (i < exp_n && exp_oe[i] && cap_o[i] !== exp_o[i]) bad++;
        end
        chk({req, " frame bits"}, 32'(bad), 32'd0);
        chk("R1 MDC phase lengths", 32'(bad_hi + bad_lo), 32'd0);
    endtask

    // fields: rd, phy, reg, wdata, reply
    localparam logic [42:0] VEC [8] = '{
        {1'b1, 5'd1,  5'd1,  16'h0000, 16'h786D},
        {1'b1, 5'd31, 5'd0,  16'h0000, 16'hAAAA},
        {1'b1, 5'd0,  5'd30, 16'h0000, 16'h0000},
        {1'b1, 5'd21, 5'd10, 16'h0000, 16'hFFFF},
        {1'b0, 5'd16, 5'd4,  16'h01E1, 16'h0000},
        {1'b0, 5'd21, 5'd31, 16'h0000, 16'h0000},
        {1'b0, 5'd10, 5'd21, 16'hFFFF, 16'h0000},
        {1'b0, 5'd31, 5'd0,  16'h5A5A, 16'h0000}
    };

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset readback", cmd_rdata, 32'h0);
        chk("R1 MDC low at rest", {31'h0, mdc}, 32'h0);
        chk("R4 MDIO released at rest", {31'h0, mdio_oe}, 32'h0);

        for (int v = 0; v < 8; v++) begin
            logic rd;
            logic [4:0] phy, rg;
            logic [15:0] wd, rsp;
            {rd, phy, rg, wd, rsp} = VEC[v];
            build_exp(rd, phy, rg, wd, rsp);
            write_cmd({4'b0, rd, !rd, phy, rg, wd});
            @(negedge clk);
            chk("R9 done cleared on accept", {31'h0, cmd_rdata[28]}, 32'h0);
            chk("R7 request bit shown while busy", {30'h0, cmd_rdata[27:26]}, {30'h0, rd, !rd});
            wait_done();
            repeat (2) @(negedge clk);
            check_frame(rd ? "R3" : "R5");
            chk(rd ? "R4 read frame length" : "R5 write frame length", 32'(rises), 32'(exp_n));
            chk(rd ? "R4 read result" : "R7 write readback",
                cmd_rdata, {3'b0, 1'b1, 2'b00, phy, rg, rd ? rsp : wd});
        end

        // R8 refused read
        write_cmd({2'b0, 1'b1, 1'b0, 2'b10, 5'd3, 5'd7, 16'h1234});
        repeat (10) @(negedge clk);
        chk("R8 refused read data", cmd_rdata, {2'b0, 1'b1, 1'b1, 2'b00, 5'd3, 5'd7, 16'hFFFF});
        chk("R8 refused read no MDC", 32'(rises), 32'd0);

        // R8 refused write: data field keeps 0xFFFF
        write_cmd({2'b0, 1'b1, 1'b0, 2'b01, 5'd4, 5'd8, 16'h1234});
        repeat (10) @(negedge clk);
        chk("R8 refused write data kept", {16'h0, cmd_rdata[15:0]}, 32'h0000FFFF);
        chk("R8 refused write done", {31'h0, cmd_rdata[28]}, 32'h1);
        chk("R8 refused write no MDC", 32'(rises), 32'd0);

        // R11 both bits: read wins
        build_exp(1'b1, 5'd9, 5'd2, 16'h0, 16'h0F0F);
        write_cmd({4'b0, 2'b11, 5'd9, 5'd2, 16'hBEEF});
        wait_done();
        repeat (2) @(negedge clk);
        check_frame("R11");
        chk("R11 read frame length", 32'(rises), 32'd66);
        chk("R11 read result", {16'h0, cmd_rdata[15:0]}, 32'h00000F0F);

        // R10 request during frame ignored
        build_exp(1'b0, 5'd5, 5'd6, 16'hC3C3, 16'h0);
        write_cmd({4'b0, 2'b01, 5'd5, 5'd6, 16'hC3C3});
        repeat (40) @(posedge clk);
        write_cmd({4'b0, 2'b10, 5'd17, 5'd18, 16'h0000});
        wait_done();
        repeat (2) @(negedge clk);
        check_frame("R10");
        chk("R10 fields unchanged", cmd_rdata, {3'b0, 1'b1, 2'b00, 5'd5, 5'd6, 16'hC3C3});
        chk("R10 frame length", 32'(rises), 32'd67);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=no_done expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule